// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is a two-address, byte-wide configuration port of the kind used on legacy I/O buses. Address 0 is an index register and address 1 is a data window onto whichever register the index names. The register space stays sealed until the host writes a fixed key byte to the index address twice in a row. An exit byte written to the index address seals it again.

Once the port is open, the host can read fixed identification bytes and a device-number register. Through the data window it can also reach a small bank of registers for each logical device, chosen by that device number. Each bank holds a 16-bit base address, interrupt share and trigger bits, and FIFO depth and receive-threshold bits. All per-device fields are driven out as flat output buses for the serial datapath that sits beside this block.

The host bus is a plain strobe interface with no back-pressure. Any read or write strobe is accepted in the cycle it is high. Read data is registered, so it appears one clock after the read strobe and holds until the next read.

Top module: `cfg_key_port`

## Requirements
- R1: After reset the port is sealed (`cfg_open` = 0), `bus_rdata` is 0x00 and every per-device output field is zero.
- R2: The port opens only after two index-address writes in a row both carry the KEY parameter byte (legal values 0x77, 0xA0, 0x87, 0x67; default 0x87). Any other index write while sealed restarts the match. Data-address writes do not affect the match.
- R3: Writing 0xAA to the index address while open seals the port in the next cycle. The index register is not changed by that write.
- R4: While sealed, reads at either address return 0xFF, and data-address writes change no register.
- R5: Identification registers read as follows: index 0x20 gives CHIP_ID[7:0], 0x21 gives CHIP_ID[15:8], 0x23 gives 0x19 and 0x24 gives 0x34. Writes to them have no effect.
- R6: Index 0x07 is an 8-bit device-number register that reads back what was written.
- R7: For the selected device, index 0x60 holds base-address bits 15:8 and index 0x61 holds bits 7:0. Device i drives `dev_base[16*i+15:16*i]`.
- R8: For the selected device, index 0x70 bit 4 is interrupt share and bits 6:5 are the trigger mode (00 = level/active-low, 01 = edge/active-high). Its other bits read 0.
- R9: For the selected device, index 0xF6 bits 1:0 are the FIFO mode (11 = 128-byte) and bits 5:4 are the receive-threshold mode (10 = 4x scale). Its other bits read 0.
- R10: Reads of unimplemented indices, and of per-device indices while the device number is NDEV or more, return 0x00. Per-device writes in that case are ignored.
- R11: `bus_rdata` loads on each clock edge at which `bus_rd` is high and otherwise holds. A read in the same cycle as a write returns the value from before that write.
- R12: While open, a read at the index address returns the current index register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 = index address, 1 = data address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | High while configuration access is open |
| dev_base | output | 16*NDEV | Base address per device |
| dev_irq_share | output | NDEV | Interrupt share enable per device |
| dev_irq_trig | output | 2*NDEV | Trigger mode per device |
| dev_fifo_mode | output | 2*NDEV | FIFO mode per device |
| dev_rx_thr | output | 2*NDEV | Receive-threshold mode per device |

## Verification
A read strobe and a write strobe can land in the same cycle. The bench provokes this in two ways: a data-address read together with a write to the same base-address byte, and an index read together with the exit byte. In both cases the returned byte must be the pre-write value. At the same time, the write must take effect, and this is judged on the next read and on the output buses. The behavioural model compares every output on every clock, so a collision that leaks the new value, or that drops the write, is caught in the cycle it shows up.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam logic [7:0] EXIT_CODE   = 8'hAA;
  localparam logic [7:0] IDX_DEVNUM  = 8'h07;
  localparam logic [7:0] IDX_CHIP_LO = 8'h20;
  localparam logic [7:0] IDX_CHIP_HI = 8'h21;
  localparam logic [7:0] IDX_VEND_A  = 8'h23;
  localparam logic [7:0] IDX_VEND_B  = 8'h24;
  localparam logic [7:0] VEND_A_VAL  = 8'h19;
  localparam logic [7:0] VEND_B_VAL  = 8'h34;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_IRQ     = 8'h70;
  localparam logic [7:0] IDX_FIFO    = 8'hF6;
  localparam logic [7:0] SEALED_READ = 8'hFF;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_st_t;

  typedef struct packed {
    logic [15:0] base;
    logic        share;
    logic [1:0]  trig;
    logic [1:0]  fifo;
    logic [1:0]  rxthr;
  } dev_cfg_t;
endpackage

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
  import cfgp_pkg::*;
#(
  parameter logic [7:0] KEY = 8'h87
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open_o
);
  lock_st_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LK_IDLE;
    end else if (idx_wr) begin
      unique case (state)
        LK_IDLE: state <= (wdata == KEY) ? LK_HALF : LK_IDLE;
        LK_HALF: state <= (wdata == KEY) ? LK_OPEN : LK_IDLE;
        LK_OPEN: state <= (wdata == EXIT_CODE) ? LK_IDLE : LK_OPEN;
        default: state <= LK_IDLE;
      endcase
    end
  end

  assign open_o = (state == LK_OPEN);
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output dev_cfg_t   cfg,
  output logic [7:0] rd_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      case (idx)
        IDX_BASE_HI: cfg.base[15:8] <= wdata;
        IDX_BASE_LO: cfg.base[7:0]  <= wdata;
        IDX_IRQ: begin
          cfg.share <= wdata[4];
          cfg.trig  <= wdata[6:5];
        end
        IDX_FIFO: begin
          cfg.fifo  <= wdata[1:0];
          cfg.rxthr <= wdata[5:4];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_BASE_HI: rd_val = cfg.base[15:8];
      IDX_BASE_LO: rd_val = cfg.base[7:0];
      IDX_IRQ:     rd_val = {1'b0, cfg.trig, cfg.share, 4'b0000};
      IDX_FIFO:    rd_val = {2'b00, cfg.rxthr, 2'b00, cfg.fifo};
      default:     rd_val = 8'h00;
    endcase
  end
endmodule

// File: rtl/cfg_read_sel.sv
module cfg_read_sel
  import cfgp_pkg::*;
#(
  parameter logic [15:0] CHIP_ID = 16'h3A51
) (
  input  logic       open_i,
  input  logic       addr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] devnum_i,
  input  logic       dev_ok_i,
  input  logic [7:0] dev_rd_i,
  output logic [7:0] value_o
);
  logic [7:0] data_val;

  always_comb begin
    case (idx_i)
      IDX_DEVNUM:  data_val = devnum_i;
      IDX_CHIP_LO: data_val = CHIP_ID[7:0];
      IDX_CHIP_HI: data_val = CHIP_ID[15:8];
      IDX_VEND_A:  data_val = VEND_A_VAL;
      IDX_VEND_B:  data_val = VEND_B_VAL;
      default:     data_val = dev_ok_i ? dev_rd_i : 8'h00;
    endcase
  end

  always_comb begin
    if (!open_i)      value_o = SEALED_READ;
    else if (!addr_i) value_o = idx_i;
    else              value_o = data_val;
  end
endmodule

// File: rtl/cfg_key_port.sv
module cfg_key_port
  import cfgp_pkg::*;
#(
  parameter int          NDEV    = 5,
  parameter logic [7:0]  KEY     = 8'h87,
  parameter logic [15:0] CHIP_ID = 16'h3A51
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic                cfg_open,
  output logic [16*NDEV-1:0]  dev_base,
  output logic [NDEV-1:0]     dev_irq_share,
  output logic [2*NDEV-1:0]   dev_irq_trig,
  output logic [2*NDEV-1:0]   dev_fifo_mode,
  output logic [2*NDEV-1:0]   dev_rx_thr
);
  localparam logic [7:0] NDEV_B = 8'(NDEV);

  logic       idx_wr, data_wr;
  logic [7:0] idx_q, devnum_q;
  logic       dev_ok;
  logic [7:0] dev_rd [NDEV];
  logic [7:0] dev_rd_sel;
  logic [7:0] rd_next;
  dev_cfg_t   dev_cfg [NDEV];

  assign idx_wr  = bus_wr && !bus_addr;
  assign data_wr = bus_wr && bus_addr && cfg_open;
  assign dev_ok  = (devnum_q < NDEV_B);

  cfg_unlock_fsm #(.KEY(KEY)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (idx_wr),
    .wdata  (bus_wdata),
    .open_o (cfg_open)
  );

  // index and device-number registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= 8'h00;
      devnum_q <= 8'h00;
    end else begin
      if (idx_wr && cfg_open && bus_wdata != EXIT_CODE) idx_q <= bus_wdata;
      if (data_wr && idx_q == IDX_DEVNUM) devnum_q <= bus_wdata;
    end
  end

  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    logic wr_i;
    assign wr_i = data_wr && (devnum_q == 8'(i));

    cfg_dev_bank u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_i),
      .idx    (idx_q),
      .wdata  (bus_wdata),
      .cfg    (dev_cfg[i]),
      .rd_val (dev_rd[i])
    );

    assign dev_base[16*i +: 16]    = dev_cfg[i].base;
    assign dev_irq_share[i]        = dev_cfg[i].share;
    assign dev_irq_trig[2*i +: 2]  = dev_cfg[i].trig;
    assign dev_fifo_mode[2*i +: 2] = dev_cfg[i].fifo;
    assign dev_rx_thr[2*i +: 2]    = dev_cfg[i].rxthr;
  end

  always_comb begin
    dev_rd_sel = 8'h00;
    for (int i = 0; i < NDEV; i++) begin
      if (devnum_q == 8'(i)) dev_rd_sel = dev_rd[i];
    end
  end

  cfg_read_sel #(.CHIP_ID(CHIP_ID)) u_rsel (
    .open_i   (cfg_open),
    .addr_i   (bus_addr),
    .idx_i    (idx_q),
    .devnum_i (devnum_q),
    .dev_ok_i (dev_ok),
    .dev_rd_i (dev_rd_sel),
    .value_o  (rd_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/cfg_key_port_chk.sv
module cfg_key_port_chk #(
  parameter int         NDEV = 5,
  parameter logic [7:0] KEY  = 8'h87
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_addr,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic [7:0]         bus_wdata,
  input logic [7:0]         bus_rdata,
  input logic               cfg_open,
  input logic [16*NDEV-1:0] dev_base,
  input logic [NDEV-1:0]    dev_irq_share,
  input logic [2*NDEV-1:0]  dev_irq_trig,
  input logic [2*NDEV-1:0]  dev_fifo_mode,
  input logic [2*NDEV-1:0]  dev_rx_thr
);
  assert_unlock_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(bus_wr && !bus_addr && bus_wdata == KEY));

  assert_exit_seals_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=> !cfg_open);

  assert_sealed_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && bus_rd) |=> (bus_rdata == 8'hFF));

  assert_sealed_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && bus_wr && bus_addr) |=>
      ($stable(dev_base) && $stable(dev_irq_share) && $stable(dev_irq_trig) &&
       $stable(dev_fifo_mode) && $stable(dev_rx_thr)));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind cfg_key_port cfg_key_port_chk #(.NDEV(NDEV), .KEY(KEY)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_rd        (bus_rd),
  .bus_wr        (bus_wr),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .cfg_open      (cfg_open),
  .dev_base      (dev_base),
  .dev_irq_share (dev_irq_share),
  .dev_irq_trig  (dev_irq_trig),
  .dev_fifo_mode (dev_fifo_mode),
  .dev_rx_thr    (dev_rx_thr)
);

// File: tb/sim_cfg_key_port.sv
`timescale 1ns/1ps
module sim_cfg_key_port;
  localparam int          NDEV = 5;
  localparam logic [7:0]  KEY  = 8'h87;
  localparam logic [15:0] CID  = 16'h3A51;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata;
  logic open;
  logic [16*NDEV-1:0] base;
  logic [NDEV-1:0] share;
  logic [2*NDEV-1:0] trig, fifo, rxthr;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  cfg_key_port #(.NDEV(NDEV), .KEY(KEY), .CHIP_ID(CID)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(a), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wd), .bus_rdata(rdata), .cfg_open(open), .dev_base(base),
    .dev_irq_share(share), .dev_irq_trig(trig), .dev_fifo_mode(fifo),
    .dev_rx_thr(rxthr));

  // behavioural reference model
  int m_st;            // 0 sealed, 1 one key seen, 2 open
  int m_idx, m_dev, m_rd;
  int m_base[NDEV], m_irq[NDEV], m_fifo[NDEV];
  string m_tag;

  task automatic expect_eq(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_dev = 0; m_rd = 0; m_tag = "R1";
      for (int i = 0; i < NDEV; i++) begin
        m_base[i] = 0; m_irq[i] = 0; m_fifo[i] = 0;
      end
    end else begin
      if (rd) begin
        if (m_st != 2) begin m_rd = 'hFF; m_tag = "R4"; end
        else if (!a) begin m_rd = m_idx; m_tag = "R12"; end
        else begin
          case (m_idx)
            'h07: begin m_rd = m_dev; m_tag = "R6"; end
            'h20: begin m_rd = CID[7:0]; m_tag = "R5"; end
            'h21: begin m_rd = CID[15:8]; m_tag = "R5"; end
            'h23: begin m_rd = 'h19; m_tag = "R5"; end
            'h24: begin m_rd = 'h34; m_tag = "R5"; end
            'h60, 'h61, 'h70, 'hF6: begin
              if (m_dev >= NDEV) begin m_rd = 0; m_tag = "R10"; end
              else if (m_idx == 'h60) begin m_rd = m_base[m_dev] / 256; m_tag = "R7"; end
              else if (m_idx == 'h61) begin m_rd = m_base[m_dev] % 256; m_tag = "R7"; end
              else if (m_idx == 'h70) begin m_rd = m_irq[m_dev]; m_tag = "R8"; end
              else begin m_rd = m_fifo[m_dev]; m_tag = "R9"; end
            end
            default: begin m_rd = 0; m_tag = "R10"; end
          endcase
        end
        if (wr) m_tag = "R11";
      end
      if (wr && !a) begin
        if (m_st == 2) begin
          if (wd == 8'hAA) m_st = 0; else m_idx = wd;
        end else if (wd == KEY) m_st = m_st + 1;
        else m_st = 0;
      end else if (wr && a && m_st == 2) begin
        if (m_idx == 'h07) m_dev = wd;
        else if (m_dev < NDEV) begin
          case (m_idx)
            'h60: m_base[m_dev] = (m_base[m_dev] % 256) + wd * 256;
            'h61: m_base[m_dev] = (m_base[m_dev] / 256) * 256 + wd;
            'h70: m_irq[m_dev] = wd & 'h70;
            'hF6: m_fifo[m_dev] = wd & 'h33;
            default: ;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      expect_eq(m_tag, rdata, m_rd);
      expect_eq("R2 R3 open state", open, m_st == 2);
      for (int i = 0; i < NDEV; i++) begin
        expect_eq("R7 base out", base[16*i +: 16], m_base[i]);
        expect_eq("R8 share out", share[i], (m_irq[i] >> 4) & 1);
        expect_eq("R8 trig out", trig[2*i +: 2], (m_irq[i] >> 5) & 3);
        expect_eq("R9 fifo out", fifo[2*i +: 2], m_fifo[i] & 3);
        expect_eq("R9 rxthr out", rxthr[2*i +: 2], (m_fifo[i] >> 4) & 3);
      end
    end
  end

  task automatic op(input logic ad, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    a = ad; rd = r; wr = w; wd = d;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] idx, input logic [7:0] d);
    op(1'b0, 1'b0, 1'b1, idx);
    op(1'b1, 1'b0, 1'b1, d);
  endtask

  task automatic rreg(input logic [7:0] idx);
    op(1'b0, 1'b0, 1'b1, idx);
    op(1'b1, 1'b1, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_eq("R1 rdata", rdata, 0);
    expect_eq("R1 open", open, 0);
    expect_eq("R1 base", base == '0, 1);
    expect_eq("R1 fields", {share, trig, fifo, rxthr} == '0, 1);
    // R4 sealed: reads 0xFF, data writes dropped
    op(1'b1, 1'b1, 1'b0, 8'h00);
    op(1'b0, 1'b1, 1'b0, 8'h00);
    op(1'b1, 1'b0, 1'b1, 8'h5A);
    // R2 interrupted key, then exit byte between keys, then data write between keys
    op(1'b0, 1'b0, 1'b1, KEY);
    op(1'b0, 1'b0, 1'b1, 8'h12);
    op(1'b0, 1'b0, 1'b1, KEY);
    op(1'b0, 1'b0, 1'b1, 8'hAA);
    op(1'b0, 1'b0, 1'b1, KEY);
    op(1'b1, 1'b0, 1'b1, KEY);
    op(1'b0, 1'b0, 1'b1, KEY);
    expect_eq("R2 open after key pair", open, 1);
    // R12 index readback
    op(1'b0, 1'b0, 1'b1, 8'h3C);
    op(1'b0, 1'b1, 1'b0, 8'h00);
    // R5 ids, write attempts
    rreg(8'h20); rreg(8'h21); rreg(8'h23); rreg(8'h24);
    wreg(8'h20, 8'h00); wreg(8'h23, 8'hFF);
    rreg(8'h20); rreg(8'h23);
    // R6 R7 R8 R9 per device
    for (int i = 0; i < NDEV; i++) begin
      wreg(8'h07, 8'(i));
      rreg(8'h07);
      wreg(8'h60, 8'(8'h10 + i));
      wreg(8'h61, 8'(8'hF0 - i));
      wreg(8'h70, (i % 2) ? 8'hFF : 8'h30);
      wreg(8'hF6, (i % 2) ? 8'hFF : 8'h23);
    end
    for (int i = 0; i < NDEV; i++) begin
      wreg(8'h07, 8'(i));
      rreg(8'h60); rreg(8'h61); rreg(8'h70); rreg(8'hF6);
    end
    // R10 out-of-range device and unimplemented index
    wreg(8'h07, 8'(NDEV));
    wreg(8'h60, 8'hEE);
    wreg(8'h70, 8'hFF);
    rreg(8'h60); rreg(8'hF6);
    rreg(8'h55);
    // R11 read and write in the same cycle
    wreg(8'h07, 8'd2);
    op(1'b0, 1'b0, 1'b1, 8'h61);
    op(1'b1, 1'b1, 1'b1, 8'h99);
    op(1'b1, 1'b1, 1'b0, 8'h00);
    expect_eq("R11 collision write landed", base[16*2 +: 8], 8'h99);
    // R3 exit collides with an index read
    op(1'b0, 1'b1, 1'b1, 8'hAA);
    expect_eq("R3 sealed after exit", open, 0);
    op(1'b1, 1'b1, 1'b0, 8'h00);
    op(1'b1, 1'b0, 1'b1, 8'h01);
    // R2 reopen, index kept across exit (R3)
    op(1'b0, 1'b0, 1'b1, KEY);
    op(1'b0, 1'b0, 1'b1, KEY);
    op(1'b1, 1'b1, 1'b0, 8'h00);
    op(1'b0, 1'b1, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule